// File: doc/BRIEF.md
# SMBus Register Target with Bus Timeout Recovery

This block is the target side of a two-wire SMBus/I2C link. It oversamples the clock and data lines with the system clock and detects START and STOP conditions. It takes in an address byte and compares its seven upper bits with a strapped own address. On a match it acknowledges. It then exchanges bytes with a small internal register file through an auto-incrementing pointer.

A controller first writes a pointer byte and then any number of data bytes. To read, it sets the pointer, issues a repeated START with the read direction and clocks bytes out until it answers with a NACK. After each byte it has received, the target can hold the clock low until the local side raises `appReady`. A counter measures how long the clock has been held low. When that time passes a parameterised limit, the target releases both lines and drops back to idle. This lets the bus recover from a target or controller that has hung.

Both lines are open-drain. The block reads the resolved line levels on `sclIn` and `sdaIn`. It pulls a line low by raising `sclOe` or `sdaOe`.

Top module: `smb_target`

## Requirements
- R1: The address byte carries the address in bits 7..1 and the direction in bit 0 (1 = read). When bits 7..1 equal `ownAddr`, the target pulls SDA low during the ninth clock.
- R2: After an address that does not match, the target does not acknowledge and ignores the following bytes until the next START. No register changes.
- R3: If `ownAddr` is reserved (upper four bits 0000 or 1111), the target never acknowledges and never drives either line.
- R4: The address acknowledge is given even when `appReady` is low, and no clock stretch follows it.
- R5: In a write, the first byte after the address loads the pointer (its low log2(REG_DEPTH) bits). Each later byte is stored at the pointer, and the pointer then advances, wrapping at REG_DEPTH. Every written byte is acknowledged.
- R6: At the falling clock edge that ends the acknowledge of a written byte, if `appReady` is low, the target holds SCL low. It releases SCL in the cycle after it sees `appReady` high. If `appReady` is high, there is no stretch.
- R7: After a repeated START with the read direction, the target sends the register at the pointer, MSB first, and advances the pointer for every byte it loads.
- R8: A NACK from the controller after a read byte ends the transmission. The target releases SDA and leaves it released for any further clocks until the next START.
- R9: When SCL stays low for more than TIMEOUT_CYC system clocks, the target releases SCL and SDA and goes idle. Later clocks are ignored until a START, and the byte being received is discarded.
- R10: A STOP detected in any state returns the target to idle with both lines released. The first write byte of the next transaction is again a pointer.
- R11: The target changes its SDA drive only while SCL is low.
- R12: After reset, both lines are released and every register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| ownAddr | input | 7 | Strapped 7-bit target address |
| sclIn | input | 1 | Resolved level of the SCL line |
| sdaIn | input | 1 | Resolved level of the SDA line |
| appReady | input | 1 | Local side can take the next byte; low requests clock stretching |
| sclOe | output | 1 | Pull SCL low (stretch) |
| sdaOe | output | 1 | Pull SDA low (acknowledge or data zero) |

## Verification
The assertions check the following on every cycle:
- SDA drive changes only while SCL is low.
- A stretch starts only when the local side was not ready, and it ends the cycle after it becomes ready.
- A STOP leaves both lines released.
- A clock held low past the limit finds both lines released.
- A reserved own address never drives a line.

Some behaviours need whole transactions, so only the bench's scenarios can show them:
- which register a byte lands in and how the pointer wraps;
- that read data comes out MSB first;
- that a NACK or a mismatch leaves the target silent for the following bytes;
- that a timed-out byte is not stored.

// File: rtl/smb_target_pkg.sv
package smb_target_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK_WAIT,
    ST_AACK,
    ST_WRX,
    ST_WACK_WAIT,
    ST_WACK,
    ST_STRETCH,
    ST_TX,
    ST_RACK
  } smbState_e;

  // Strobes from control to datapath, at most a few per cycle
  typedef struct packed {
    logic bitClr;    // clear the bit counter
    logic rxShift;   // shift synced SDA into receive register
    logic ptrLoad;   // load pointer from completed byte
    logic regStore;  // store completed byte at pointer, advance
    logic txLoad;    // load transmit register from pointer, advance
    logic txShift;   // present next transmit bit
  } smbStrobe_t;

  function automatic logic addrReserved(input logic [6:0] a);
    return (a[6:3] == 4'h0) || (a[6:3] == 4'hF);
  endfunction

endpackage

// File: rtl/smb_target_dp.sv
module smb_target_dp
  import smb_target_pkg::*;
#(
  parameter int REG_DEPTH   = 16,
  parameter int TIMEOUT_CYC = 1750000,
  parameter int SYNC_LEN    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [6:0] ownAddr,
  input  smbStrobe_t strobe,
  output logic       sdaS,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet,
  output logic       timeoutHit,
  output logic       bitLast,
  output logic       addrMatch,
  output logic       rwBit,
  output logic       txBit
);

  localparam int PTR_W = $clog2(REG_DEPTH);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] TO_MAX  = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);

  // ---------------- line synchronisers ----------------
  logic [SYNC_LEN-1:0] sclPipe, sdaPipe;
  logic sclS, sclPrev, sdaPrev;

  generate
    for (genvar g = 0; g < SYNC_LEN; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else if (g == 0) begin
          sclPipe[g] <= sclIn;
          sdaPipe[g] <= sdaIn;
        end else begin
          sclPipe[g] <= sclPipe[(g == 0) ? 0 : g-1];
          sdaPipe[g] <= sdaPipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_LEN-1];
  assign sdaS = sdaPipe[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  =  sclS & ~sclPrev;
  assign sclFall  = ~sclS &  sclPrev;
  assign startDet =  sclS &  sclPrev &  sdaPrev & ~sdaS;
  assign stopDet  =  sclS &  sclPrev & ~sdaPrev &  sdaS;

  // ---------------- SCL-low timeout ----------------
  logic [CNT_W-1:0] toCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              toCnt <= '0;
    else if (sclS)          toCnt <= '0;
    else if (toCnt != TO_MAX) toCnt <= toCnt + 1'b1;
  end

  assign timeoutHit = ~sclS & (toCnt == TO_LAST);

  // ---------------- shift registers ----------------
  logic [7:0] rxReg, rxNext, txReg;
  logic [2:0] bitCnt;

  assign rxNext = {rxReg[6:0], sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg  <= '0;
      bitCnt <= '0;
    end else begin
      if (strobe.rxShift) rxReg <= rxNext;
      if (strobe.bitClr || strobe.txLoad)       bitCnt <= '0;
      else if (strobe.rxShift || strobe.txShift) bitCnt <= bitCnt + 3'd1;
    end
  end

  assign bitLast   = (bitCnt == 3'd7);
  assign addrMatch = (rxNext[7:1] == ownAddr) && !addrReserved(ownAddr);
  assign rwBit     = rxNext[0];

  // ---------------- register file and pointer ----------------
  logic [7:0]       regFile [REG_DEPTH];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_DEPTH; i++) regFile[i] <= '0;
      ptr   <= '0;
      txReg <= '0;
    end else begin
      if (strobe.ptrLoad) begin
        ptr <= rxNext[PTR_W-1:0];
      end else if (strobe.regStore) begin
        regFile[ptr] <= rxNext;
        ptr          <= ptr + 1'b1;
      end else if (strobe.txLoad) begin
        txReg <= regFile[ptr];
        ptr   <= ptr + 1'b1;
      end
      if (strobe.txShift) txReg <= {txReg[6:0], 1'b0};
    end
  end

  assign txBit = txReg[7];

endmodule

// File: rtl/smb_target_ctrl.sv
module smb_target_ctrl
  import smb_target_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       timeoutHit,
  input  logic       bitLast,
  input  logic       addrMatch,
  input  logic       rwBit,
  input  logic       sdaS,
  input  logic       appReady,
  output smbStrobe_t strobe,
  output logic       sdaLow,
  output logic       txEn,
  output logic       sclHold
);

  smbState_e state, stateNxt;
  logic rwDir, rwNxt;
  logic firstWr, firstNxt;
  logic ackOk, ackNxt;
  logic sdaLowNxt, txEnNxt, holdNxt;

  always_comb begin
    stateNxt  = state;
    rwNxt     = rwDir;
    firstNxt  = firstWr;
    ackNxt    = ackOk;
    sdaLowNxt = sdaLow;
    txEnNxt   = txEn;
    holdNxt   = sclHold;
    strobe    = '0;

    if (timeoutHit || stopDet) begin
      stateNxt  = ST_IDLE;
      sdaLowNxt = 1'b0;
      txEnNxt   = 1'b0;
      holdNxt   = 1'b0;
    end else if (startDet) begin
      stateNxt      = ST_ADDR;
      strobe.bitClr = 1'b1;
      firstNxt      = 1'b1;
      sdaLowNxt     = 1'b0;
      txEnNxt       = 1'b0;
      holdNxt       = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (sclRise) begin
          strobe.rxShift = 1'b1;
          if (bitLast) begin
            if (addrMatch) begin
              rwNxt    = rwBit;
              stateNxt = ST_AACK_WAIT;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_AACK_WAIT: if (sclFall) begin
          sdaLowNxt = 1'b1;
          stateNxt  = ST_AACK;
        end
        ST_AACK: if (sclFall) begin
          sdaLowNxt = 1'b0;
          if (rwDir) begin
            strobe.txLoad = 1'b1;
            txEnNxt       = 1'b1;
            stateNxt      = ST_TX;
          end else begin
            strobe.bitClr = 1'b1;
            stateNxt      = ST_WRX;
          end
        end
        ST_WRX: if (sclRise) begin
          strobe.rxShift = 1'b1;
          if (bitLast) begin
            if (firstWr) strobe.ptrLoad  = 1'b1;
            else         strobe.regStore = 1'b1;
            firstNxt = 1'b0;
            stateNxt = ST_WACK_WAIT;
          end
        end
        ST_WACK_WAIT: if (sclFall) begin
          sdaLowNxt = 1'b1;
          stateNxt  = ST_WACK;
        end
        ST_WACK: if (sclFall) begin
          sdaLowNxt     = 1'b0;
          strobe.bitClr = 1'b1;
          if (appReady) begin
            stateNxt = ST_WRX;
          end else begin
            holdNxt  = 1'b1;
            stateNxt = ST_STRETCH;
          end
        end
        ST_STRETCH: if (appReady) begin
          holdNxt  = 1'b0;
          stateNxt = ST_WRX;
        end
        ST_TX: if (sclFall) begin
          if (bitLast) begin
            txEnNxt  = 1'b0;
            stateNxt = ST_RACK;
          end else begin
            strobe.txShift = 1'b1;
          end
        end
        ST_RACK: begin
          if (sclRise) ackNxt = ~sdaS;
          if (sclFall) begin
            if (ackOk) begin
              strobe.txLoad = 1'b1;
              txEnNxt       = 1'b1;
              stateNxt      = ST_TX;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rwDir   <= 1'b0;
      firstWr <= 1'b0;
      ackOk   <= 1'b0;
      sdaLow  <= 1'b0;
      txEn    <= 1'b0;
      sclHold <= 1'b0;
    end else begin
      state   <= stateNxt;
      rwDir   <= rwNxt;
      firstWr <= firstNxt;
      ackOk   <= ackNxt;
      sdaLow  <= sdaLowNxt;
      txEn    <= txEnNxt;
      sclHold <= holdNxt;
    end
  end

endmodule

// File: rtl/smb_target.sv
module smb_target
  import smb_target_pkg::*;
#(
  parameter int REG_DEPTH   = 16,
  parameter int TIMEOUT_CYC = 1750000,
  parameter int SYNC_LEN    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] ownAddr,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       appReady,
  output logic       sclOe,
  output logic       sdaOe
);

  smbStrobe_t strobe;
  logic sdaS, sclRise, sclFall, startDet, stopDet, timeoutHit;
  logic bitLast, addrMatch, rwBit, txBit;
  logic sdaLow, txEn, sclHold;

  smb_target_dp #(
    .REG_DEPTH  (REG_DEPTH),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .SYNC_LEN   (SYNC_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ownAddr   (ownAddr),
    .strobe    (strobe),
    .sdaS      (sdaS),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .timeoutHit(timeoutHit),
    .bitLast   (bitLast),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .txBit     (txBit)
  );

  smb_target_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .timeoutHit(timeoutHit),
    .bitLast   (bitLast),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .sdaS      (sdaS),
    .appReady  (appReady),
    .strobe    (strobe),
    .sdaLow    (sdaLow),
    .txEn      (txEn),
    .sclHold   (sclHold)
  );

  assign sdaOe = sdaLow | (txEn & ~txBit);
  assign sclOe = sclHold;

endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk #(
  parameter int TIMEOUT_CYC = 1750000
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       appReady,
  input logic [6:0] ownAddr,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       stopDet
);

  // Counts raw SCL-low cycles, saturating just past the window of interest
  int lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          lowCnt <= 0;
    else if (sclIn)                     lowCnt <= 0;
    else if (lowCnt < TIMEOUT_CYC + 8)  lowCnt <= lowCnt + 1;
  end

  // R11: SDA drive moves only while SCL is low
  p_sda_move_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R6: a stretch begins only when the local side was not ready
  p_stretch_when_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> !$past(appReady));

  // R6: readiness ends the stretch on the next cycle
  p_stretch_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && appReady) |=> !sclOe);

  // R10: a STOP leaves both lines released
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sdaOe && !sclOe));

  // R9: SCL low beyond the limit finds the target off the bus
  p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lowCnt >= TIMEOUT_CYC + 6) |-> (!sdaOe && !sclOe));

  // R3: a reserved own address never touches the lines
  p_reserved_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((ownAddr[6:3] == 4'h0) || (ownAddr[6:3] == 4'hF)) |-> (!sdaOe && !sclOe));

endmodule

bind smb_target smb_target_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .appReady(appReady),
  .ownAddr (ownAddr),
  .sclOe   (sclOe),
  .sdaOe   (sdaOe),
  .stopDet (stopDet)
);

// File: tb/sim_smb_target.sv
module sim_smb_target;

  localparam int   DEPTH = 16;
  localparam int   TB_TO = 400;
  localparam int   H     = 12;
  localparam logic [6:0] OWN = 7'h2D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] ownAddr = OWN;
  logic appReady = 1'b1;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sclOe, sdaOe, sclLine, sdaLine;

  assign sclLine = sclDrv & ~sclOe;
  assign sdaLine = sdaDrv & ~sdaOe;

  always #10 clk = ~clk;   // 50 MHz

  smb_target #(.REG_DEPTH(DEPTH), .TIMEOUT_CYC(TB_TO), .SYNC_LEN(2)) u0 (
    .clk(clk), .rstN(rstN), .ownAddr(ownAddr), .sclIn(sclLine), .sdaIn(sdaLine),
    .appReady(appReady), .sclOe(sclOe), .sdaOe(sdaOe));

  int nChecks = 0, nFail = 0;
  int lastStretch = 0, entryStretch = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  function automatic logic [7:0] addrByte(input logic [6:0] a, input bit rd);
    return {a, rd};
  endfunction

  function automatic int wrapPtr(input int p);
    return p % DEPTH;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclUp();
    int c = 0;
    sclDrv = 1'b1;
    wt(1);
    while (!sclLine && c < 100000) begin wt(1); c++; end
    lastStretch = c;
  endtask

  task automatic busStart();
    sdaDrv = 1'b0; wt(H);
    sclDrv = 1'b0; wt(H/2);
  endtask

  task automatic busRestart();
    sdaDrv = 1'b1; wt(H/2);
    sclUp(); entryStretch = lastStretch; wt(H);
    sdaDrv = 1'b0; wt(H);
    sclDrv = 1'b0; wt(H/2);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; wt(H/2);
    sclUp(); entryStretch = lastStretch; wt(H);
    sdaDrv = 1'b1; wt(H);
  endtask

  task automatic bitIo(input bit b, output bit r);
    sdaDrv = b; wt(H/2);
    sclUp(); wt(H/2);
    r = sdaLine; wt(H/2);
    sclDrv = 1'b0; wt(H/2);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bitIo(v[i], r);
      if (i == 7) entryStretch = lastStretch;
    end
    bitIo(1'b1, r);
    ack = !r;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bitIo(1'b1, r);
      d[i] = r;
    end
    bitIo(!giveAck, r);
  endtask

  // Full write: pointer then data bytes (data taken from the model)
  task automatic writeSeq(input int p, input int n, input string req);
    bit ack;
    busStart();
    sendByte(addrByte(OWN, 1'b0), ack); check(ack, {req, " addr ack"}, ack, 1);
    sendByte(8'(p), ack);               check(ack, {req, " ptr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(model[wrapPtr(p + k)], ack);
      check(ack, {req, " data ack"}, ack, 1);
    end
    busStop();
  endtask

  task automatic readSeq(input int p, input int n, input string req);
    bit ack;
    logic [7:0] d;
    busStart();
    sendByte(addrByte(OWN, 1'b0), ack); check(ack, {req, " addr ack"}, ack, 1);
    sendByte(8'(p), ack);               check(ack, {req, " ptr ack"}, ack, 1);
    busRestart();
    sendByte(addrByte(OWN, 1'b1), ack); check(ack, {req, " read addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, d);
      check(d == model[wrapPtr(p + k)], {req, " read data"}, d, model[wrapPtr(p + k)]);
    end
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'h0051_C0DE));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    wt(5);
    rstN = 1'b1;
    wt(5);

    // R12: released lines and zeroed registers after reset
    check(!sclOe && !sdaOe, "R12 lines released", {sclOe, sdaOe}, 0);
    readSeq(0, 2, "R12");

    // R1 R5: directed write, R7: read back with repeated START
    model[3] = 8'hA5; model[4] = 8'h3C; model[5] = 8'h81;
    writeSeq(3, 3, "R5");
    readSeq(3, 3, "R7");

    // R5: pointer wraps at the top of the register file
    model[15] = 8'h5E; model[0] = 8'hE1;
    writeSeq(15, 2, "R5 wrap");
    readSeq(15, 2, "R7 wrap");

    // R6: ready local side gives no stretch
    busStart();
    sendByte(addrByte(OWN, 1'b0), ack);
    sendByte(8'd7, ack);
    model[7] = 8'h77;
    sendByte(model[7], ack);
    check(entryStretch == 0, "R6 no stretch when ready", entryStretch, 0);
    busStop();
    check(entryStretch == 0, "R6 no stretch after data", entryStretch, 0);

    // R4: address ACK while busy, no stretch after it; R6: stretch until ready
    appReady = 1'b0;
    busStart();
    sendByte(addrByte(OWN, 1'b0), ack);
    check(ack, "R4 addr ack while busy", ack, 1);
    sendByte(8'd9, ack);
    check(entryStretch == 0, "R4 no stretch after addr ack", entryStretch, 0);
    check(ack, "R4 ptr ack", ack, 1);
    model[9] = 8'hC6;
    fork
      sendByte(model[9], ack);
      begin
        while (!sclOe) wt(1);
        wt(50);
        appReady = 1'b1;
      end
    join
    check(entryStretch >= 30 && entryStretch <= 60, "R6 stretch length", entryStretch, 45);
    check(ack, "R6 data ack after stretch", ack, 1);
    busStop();
    readSeq(9, 1, "R6");

    // R9: local side never ready -> timeout releases the bus, byte discarded
    appReady = 1'b0;
    busStart();
    sendByte(addrByte(OWN, 1'b0), ack);
    sendByte(8'd11, ack);
    sendByte(8'hE7, ack);
    check(entryStretch >= TB_TO - 24 && entryStretch <= TB_TO,
          "R9 timeout release time", entryStretch, TB_TO - 11);
    check(!ack, "R9 ignored after timeout", ack, 0);
    busStop();
    appReady = 1'b1;
    readSeq(11, 1, "R9 byte discarded");

    // R2: mismatching address ignored, registers untouched
    busStart();
    sendByte(addrByte(OWN ^ 7'h01, 1'b0), ack);
    check(!ack, "R2 no ack on mismatch", ack, 0);
    sendByte(8'd3, ack);
    check(!ack, "R2 following byte ignored", ack, 0);
    sendByte(8'hFF, ack);
    check(!ack, "R2 data ignored", ack, 0);
    busStop();
    readSeq(3, 1, "R2 register kept");

    // R3: reserved own addresses never acknowledge
    for (int j = 0; j < 2; j++) begin
      logic [6:0] rsv;
      rsv = (j == 0) ? 7'h05 : 7'h7A;
      ownAddr = rsv;
      busStart();
      sendByte(addrByte(rsv, 1'b0), ack);
      check(!ack, "R3 reserved address silent", ack, 0);
      busStop();
    end
    ownAddr = OWN;

    // R8: NACK ends the read; further clocks see a released SDA
    model[12] = 8'h12; model[13] = 8'h34;
    writeSeq(12, 2, "R8 setup");
    busStart();
    sendByte(addrByte(OWN, 1'b0), ack);
    sendByte(8'd12, ack);
    busRestart();
    sendByte(addrByte(OWN, 1'b1), ack);
    recvByte(1'b1, d);
    check(d == 8'h12, "R8 first byte", d, 8'h12);
    recvByte(1'b0, d);
    check(d == 8'h34, "R8 byte before NACK", d, 8'h34);
    recvByte(1'b0, d);
    check(d == 8'hFF, "R8 released after NACK", d, 8'hFF);
    busStop();

    // R10: STOP returns to idle; clocks without START ignored; next write re-points
    model[5] = 8'h11;
    busStart();
    sendByte(addrByte(OWN, 1'b0), ack);
    sendByte(8'd5, ack);
    sendByte(model[5], ack);
    busStop();
    sclDrv = 1'b0; wt(H/2);
    sendByte(8'h99, ack);
    check(!ack, "R10 ignored after STOP", ack, 0);
    busStop();
    model[2] = 8'h22;
    writeSeq(2, 1, "R10 pointer again");
    readSeq(5, 2, "R10");
    readSeq(2, 1, "R10");

    // Random traffic against the bench model (R5, R7)
    for (int t = 0; t < 24; t++) begin
      int p, n;
      p = $urandom_range(0, DEPTH - 1);
      n = $urandom_range(1, 4);
      if ($urandom_range(0, 1) == 0) begin
        for (int k = 0; k < n; k++) model[wrapPtr(p + k)] = 8'($urandom);
        writeSeq(p, n, "R5 random");
      end else begin
        readSeq(p, n, "R7 random");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule